// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block produces a periodic interrupt event from a 32.768 kHz time base that reaches it as a single-cycle tick strobe in the system clock domain. A 16-bit free-running tick counter advances on every strobe. A 4-bit rate code chooses a power-of-two period, counted in base ticks. An event is raised each time the counter lands on a multiple of that period. Because events are tied to period-aligned counter values rather than to the moment of programming, a new rate takes effect at the next boundary of the new period.

Each event is a one-cycle pulse, together with an 8-bit set mask for the periodic and summary bits of an external interrupt status register. The register bus, the status register itself, the calendar and the interrupt-line arbitration all sit outside the block. A rate code of zero, or a low enable, silences the generator. A tick that arrives in the same cycle as a change to the rate code or enable never produces an event; the new setting applies from the following tick.

Top module: `pig_periodic`

## Requirements
- R1: A synchronous active-high reset clears the tick counter to zero and holds `event_o` low and `flag_set_o` at 0x00. After release, the first event at rate code 3 comes on the fourth tick.
- R2: The tick counter advances by exactly one on each cycle with `tick_i` high, wraps modulo 65536, and holds in cycles without a tick. Idle cycles between ticks do not move event positions.
- R3: For a rate code c from 3 to 15, events are spaced 2^(c-1) ticks apart. For example, code 3 gives one event every 4 ticks and code 15 one every 16384 ticks.
- R4: Rate code 1 gives a period of 128 ticks and rate code 2 a period of 256 ticks.
- R5: Rate code 0 produces no events, whatever the enable and the tick count.
- R6: With `enable_i` low, no events are produced at any rate code.
- R7: An event follows the tick that brings the counter to a multiple of the current period. After the period is reprogrammed, the next event comes at the next multiple of the new period, not a full period after the change.
- R8: A tick in the same cycle as a change of `rate_code_i` or `enable_i` produces no event, even on an aligned boundary. The new setting governs from the following tick.
- R9: An event appears on `event_o` for exactly one cycle, in the cycle after the clock edge that sampled the tick. In that cycle `flag_set_o` is 0xC0 (bit 7 summary, bit 6 periodic); in all other cycles it is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe at the 32.768 kHz base rate |
| rate_code_i | input | 4 | Period select; 0 stops events |
| enable_i | input | 1 | Periodic event enable |
| event_o | output | 1 | One-cycle periodic interrupt event |
| flag_set_o | output | 8 | Status bits to set: 0xC0 during an event, else 0x00 |

## Verification
Two functions can fall in the same cycle: a tick that completes an aligned period boundary, and a reprogramming of the rate code or enable. The bench provokes this by raising the tick strobe and changing the configuration on the same clock edge. It does so exactly on a boundary where the old setting would fire, and again when enabling lands on a boundary of the new period. The result is judged by the absence of an event on that tick, followed by events at the multiples of the new period only.

// File: rtl/pig_pkg.sv
package pig_pkg;
    localparam int CNT_W     = 16;
    localparam int CODE_W    = 4;
    localparam int FLAG_W    = 8;
    localparam logic [FLAG_W-1:0] FLAG_MASK = 8'hC0;
    localparam int REMAP_MAX = 2;
    localparam int REMAP_ADD = 7;

    typedef struct packed {
        logic [CODE_W-1:0] rate;
        logic              en;
        logic              pulse;
    } evt_state_t;
endpackage

// File: rtl/pig_rate_dec.sv
module pig_rate_dec #(
    parameter int CNT_W     = 16,
    parameter int CODE_W    = 4,
    parameter int REMAP_MAX = 2,
    parameter int REMAP_ADD = 7
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              active_o,
    output logic [CNT_W-1:0]  mask_o
);
    localparam int SH_W = CODE_W + 1;

    logic [SH_W-1:0] eff_code;
    logic [SH_W-1:0] shift_w;

    always_comb begin
        active_o = (code_i != '0);
        if (!active_o) begin
            eff_code = '0;
        end else if (code_i <= CODE_W'(REMAP_MAX)) begin
            eff_code = SH_W'(code_i) + SH_W'(REMAP_ADD);
        end else begin
            eff_code = SH_W'(code_i);
        end
        shift_w = active_o ? (eff_code - SH_W'(1)) : '0;
    end

    // Low 'shift_w' bits of the mask select the period - 1 boundary bits.
    for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
        assign mask_o[gi] = active_o && (SH_W'(gi) < shift_w);
    end
endmodule

// File: rtl/pig_tick_cnt.sv
module pig_tick_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_inc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cnt_inc_o = st_q.cnt + CNT_W'(1);
        if (tick_i) begin
            st_d.cnt = cnt_inc_o;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/pig_periodic.sv
module pig_periodic
    import pig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic              enable_i,
    output logic              event_o,
    output logic [FLAG_W-1:0] flag_set_o
);
    evt_state_t st_d, st_q;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] per_mask;
    logic             rate_active;
    logic             cfg_change;
    logic             on_boundary;

    pig_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .cnt_o     (cnt_q),
        .cnt_inc_o (cnt_inc)
    );

    pig_rate_dec #(
        .CNT_W     (CNT_W),
        .CODE_W    (CODE_W),
        .REMAP_MAX (REMAP_MAX),
        .REMAP_ADD (REMAP_ADD)
    ) u_dec (
        .code_i   (st_q.rate),
        .active_o (rate_active),
        .mask_o   (per_mask)
    );

    always_comb begin
        st_d        = st_q;
        cfg_change  = (rate_code_i != st_q.rate) || (enable_i != st_q.en);
        on_boundary = ((cnt_inc & per_mask) == '0);
        st_d.rate   = rate_code_i;
        st_d.en     = enable_i;
        st_d.pulse  = tick_i && st_q.en && rate_active && !cfg_change && on_boundary;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o    = st_q.pulse;
    assign flag_set_o = st_q.pulse ? FLAG_MASK : '0;
endmodule

// File: rtl/pig_periodic_chk.sv
module pig_periodic_chk
    import pig_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic [CODE_W-1:0] rate_code_i,
    input logic              enable_i,
    input logic              event_o,
    input logic [FLAG_W-1:0] flag_set_o,
    input logic [CNT_W-1:0]  cnt_q
);
    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !event_o && flag_set_o == '0); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) ($past(tick_i) && !$past(rst)) |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) (!$past(tick_i) && !$past(rst)) |-> $stable(cnt_q)); // R2
    AST_ZERO_CODE_SILENT: assert property (@(posedge clk) disable iff (rst) event_o |-> $past(rate_code_i) != '0); // R5
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst) event_o |-> $past(enable_i)); // R6
    AST_CHANGE_SUPPRESS: assert property (@(posedge clk) disable iff (rst) (tick_i && (rate_code_i != $past(rate_code_i) || enable_i != $past(enable_i))) |=> !event_o); // R8
    AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (rst) event_o |-> $past(tick_i)); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) event_o |=> !event_o); // R9
    AST_FLAG_MASK: assert property (@(posedge clk) disable iff (rst) event_o |-> flag_set_o == 8'hC0); // R9
endmodule

bind pig_periodic pig_periodic_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .rate_code_i (rate_code_i),
    .enable_i    (enable_i),
    .event_o     (event_o),
    .flag_set_o  (flag_set_o),
    .cnt_q       (cnt_q)
);

// File: tb/pig_periodic_test.sv
module pig_periodic_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [3:0] rate_code_i = 4'd0;
    logic       enable_i = 1'b0;
    logic       event_o;
    logic [7:0] flag_set_o;

    int n_checks = 0;
    int n_bad = 0;
    int m_cnt = 0;
    logic [3:0] m_rate = 4'd0;
    logic       m_en = 1'b0;
    int n_ev = 0;
    int tick_idx = 0;
    int first_ev = -1;
    int last_ev = -1;

    pig_periodic uut (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .rate_code_i (rate_code_i),
        .enable_i    (enable_i),
        .event_o     (event_o),
        .flag_set_o  (flag_set_o)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 190000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input logic [3:0] c);
        if (c == 4'd0) return 0;
        if (c == 4'd1) return 128;
        if (c == 4'd2) return 256;
        return 1 << (int'(c) - 1);
    endfunction

    task automatic clear_stats();
        n_ev = 0;
        tick_idx = 0;
        first_ev = -1;
        last_ev = -1;
    endtask

    // Model the tick outcome, then sample one clock later at a negedge.
    task automatic model_tick_and_check(input string req);
        bit changed;
        bit exp_ev;
        int p;
        changed = (rate_code_i != m_rate) || (enable_i != m_en);
        m_cnt = (m_cnt + 1) % 65536;
        p = period_of(m_rate);
        exp_ev = !changed && m_en && (p != 0) && ((m_cnt % p) == 0);
        m_rate = rate_code_i;
        m_en = enable_i;
        @(negedge clk);
        tick_i = 1'b0;
        tick_idx++;
        check(req, int'(event_o), int'(exp_ev));
        check(req, int'(flag_set_o), exp_ev ? 32'hC0 : 0);
        if (event_o) begin
            n_ev++;
            if (first_ev < 0) first_ev = tick_idx;
            last_ev = tick_idx;
        end
    endtask

    task automatic tick_once(input string req);
        @(negedge clk);
        tick_i = 1'b1;
        model_tick_and_check(req);
    endtask

    task automatic tick_with_cfg(input logic [3:0] c, input logic e, input string req);
        @(negedge clk);
        tick_i = 1'b1;
        rate_code_i = c;
        enable_i = e;
        model_tick_and_check(req);
    endtask

    task automatic ticks(input int n, input string req);
        for (int i = 0; i < n; i++) tick_once(req);
    endtask

    task automatic set_cfg(input logic [3:0] c, input logic e);
        @(negedge clk);
        rate_code_i = c;
        enable_i = e;
        @(negedge clk);
        m_rate = c;
        m_en = e;
    endtask

    task automatic do_reset(input logic [3:0] c, input logic e);
        @(negedge clk);
        rst = 1'b1;
        rate_code_i = c;
        enable_i = e;
        repeat (3) @(negedge clk);
        check("R1 reset event", int'(event_o), 0);
        check("R1 reset flags", int'(flag_set_o), 0);
        rst = 1'b0;
        @(negedge clk);
        m_cnt = 0;
        m_rate = c;
        m_en = e;
        clear_stats();
    endtask

    task automatic t_reset_state();
        do_reset(4'd3, 1'b1);
        check("R1 idle event", int'(event_o), 0);
        ticks(4, "R1 first ticks");
        check("R1 first event at tick 4", first_ev, 4);
        ticks(2, "R1 mid run");
        do_reset(4'd3, 1'b1);
        ticks(4, "R1 after mid-run reset");
        check("R1 event at tick 4 after reset", first_ev, 4);
    endtask

    task automatic t_counter_hold();
        do_reset(4'd3, 1'b1);
        ticks(2, "R2 ticks");
        repeat (10) @(negedge clk);
        check("R2 no event while idle", int'(event_o), 0);
        ticks(2, "R2 ticks after idle");
        check("R2 event on 4th tick despite idle", first_ev, 4);
    endtask

    task automatic t_fast_rate();
        do_reset(4'd3, 1'b1);
        ticks(16, "R3 code 3");
        check("R3 code 3 event count", n_ev, 4);
        check("R3 code 3 last event", last_ev, 16);
        do_reset(4'd6, 1'b1);
        ticks(96, "R3 code 6");
        check("R3 code 6 event count", n_ev, 3);
        check("R3 code 6 first event", first_ev, 32);
    endtask

    task automatic t_slowest();
        do_reset(4'd15, 1'b1);
        ticks(16384, "R3 code 15");
        check("R3 code 15 single event", n_ev, 1);
        check("R3 code 15 event tick", first_ev, 16384);
    endtask

    task automatic t_remap();
        do_reset(4'd1, 1'b1);
        ticks(256, "R4 code 1");
        check("R4 code 1 events", n_ev, 2);
        check("R4 code 1 first", first_ev, 128);
        do_reset(4'd2, 1'b1);
        ticks(512, "R4 code 2");
        check("R4 code 2 events", n_ev, 2);
        check("R4 code 2 first", first_ev, 256);
    endtask

    task automatic t_zero_code();
        do_reset(4'd0, 1'b1);
        ticks(300, "R5 code 0");
        check("R5 code 0 no events", n_ev, 0);
    endtask

    task automatic t_disabled();
        do_reset(4'd3, 1'b0);
        ticks(40, "R6 disabled");
        check("R6 disabled no events", n_ev, 0);
    endtask

    task automatic t_align();
        do_reset(4'd3, 1'b1);
        ticks(6, "R7 before reprogram");
        set_cfg(4'd5, 1'b1);
        clear_stats();
        ticks(26, "R7 after reprogram");
        check("R7 first event at next multiple of 16", first_ev, 10);
        check("R7 event count", n_ev, 2);
    endtask

    task automatic t_collide();
        do_reset(4'd3, 1'b1);
        ticks(3, "R8 lead-in");
        clear_stats();
        tick_with_cfg(4'd4, 1'b1, "R8 rate change on boundary");
        check("R8 no event on rate-change tick", n_ev, 0);
        ticks(4, "R8 after change");
        check("R8 new period event at cnt 8", first_ev, 5);
        set_cfg(4'd3, 1'b0);
        ticks(3, "R8 disabled");
        clear_stats();
        tick_with_cfg(4'd3, 1'b1, "R8 enable on boundary");
        check("R8 no event on enable tick", n_ev, 0);
        ticks(4, "R8 after enable");
        check("R8 next event one period later", first_ev, 5);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        t_counter_hold();
        t_fast_rate();
        t_remap();
        t_zero_code();
        t_disabled();
        t_align();
        t_collide();
        t_slowest();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule